// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block sits beside the bus sequencer of a PCI interface. It covers the 32 address/data lines and the 4 command/byte-enable lines with one even parity bit. The sequencer tells it what the current clock carries: an address phase, a read data phase, a write data phase or nothing. It also says whether the interface is the initiator or the target. From these two inputs the block decides, phase by phase, whether it drives the parity line or checks the parity that the other agent drives.

When a data check fails, the block pulses the active-low parity error output. When an address check fails, it pulses the active-low system error output instead. Both pulses come two clocks after the failing phase.

Each error also sets a sticky status bit: detected parity error, signalled system error, and parity error reported by another agent. A data error met while acting as initiator raises a halt request towards the initiator logic. That request appears at the end of the running burst and stays up until the host clears the errors.

Top module: `pci_parity_unit`

## Requirements
- R1: The parity output in a clock is the XOR of all 36 bits {ad_in, cbe_in} sampled in the previous clock, so that the 37 bits together hold an even number of ones.
- R2: The phase input is coded 00 idle, 01 address, 10 read data and 11 write data. par_oe is high in the clock after one of three phases: an address phase as initiator (is_master=1), a write data phase as initiator, or a read data phase as target. In every other case par_oe is low.
- R3: Parity is checked for three phases: a read data phase as initiator, an address phase as target, and a write data phase as target. For a phase in clock t, the check compares par_in sampled in clock t+1 with the parity of the bits from clock t. No other phase is checked.
- R4: A failed data-phase check drives perr_n low in clock t+2 for exactly one clock.
- R5: A failed address-phase check drives serr_n low in clock t+2 for exactly one clock and leaves perr_n high.
- R6: stat_det rises in the clock after any failed check, whether address or data, and then stays high.
- R7: stat_sys rises with every serr_n pulse and then stays high.
- R8: Suppose the block drove parity in clock t+1 for a data phase in clock t, and perr_in_n is low in clock t+2. Then stat_rpt is high from clock t+3 and stays high.
- R9: An initiator error is either a failed read data check as initiator or a report (R8) against a write data phase as initiator. After such an error has been recorded, a burst_end pulse raises halt_req in the next clock. halt_req then stays high until host_clr.
- R10: A host_clr pulse clears stat_det, stat_sys, stat_rpt, the recorded initiator error and halt_req at the next clock edge. An error event in the same clock as the pulse sets its bit anyway.
- R11: During and right after reset, par_oe, par_out, every status bit and halt_req are low, and perr_n and serr_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_in | input | AD_W | Address/data lines as seen on the bus |
| cbe_in | input | CBE_W | Command/byte-enable lines as seen on the bus |
| phase | input | 2 | Phase qualifier for the current clock (00 idle, 01 address, 10 read, 11 write) |
| is_master | input | 1 | 1 when this interface is the initiator |
| par_in | input | 1 | Parity line as seen on the bus |
| perr_in_n | input | 1 | Parity error line as seen on the bus, active low |
| burst_end | input | 1 | Pulse from the initiator logic at the end of a burst |
| host_clr | input | 1 | Host pulse that clears the error status |
| par_out | output | 1 | Parity value to drive |
| par_oe | output | 1 | Enable for the parity driver |
| perr_n | output | 1 | Parity error output, active low |
| serr_n | output | 1 | System error output, active low |
| stat_det | output | 1 | Sticky: parity error detected |
| stat_rpt | output | 1 | Sticky: parity error reported by another agent |
| stat_sys | output | 1 | Sticky: system error signalled |
| halt_req | output | 1 | Stop-operation request to the initiator logic |

## Verification
The assertions assume that the phase qualifier and role change only between clock edges, and that they describe exactly one phase per clock. The assertions look two clocks back at those inputs, so they rely on the inputs being idle through reset. The stimulus changes every input only on the falling edge and holds the phase at idle while reset is applied. Within those limits it draws phases, roles, parity flips, error reports, burst ends and clears at random, so all six role/phase pairings and back-to-back failures are exercised.

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_in,
  input  logic [CBE_W-1:0] cbe_in,
  input  logic [1:0]       phase,
  input  logic             is_master,
  input  logic             par_in,
  input  logic             perr_in_n,
  input  logic             burst_end,
  input  logic             host_clr,
  output logic             par_out,
  output logic             par_oe,
  output logic             perr_n,
  output logic             serr_n,
  output logic             stat_det,
  output logic             stat_rpt,
  output logic             stat_sys,
  output logic             halt_req
);

  localparam logic [1:0] PH_ADDR = 2'b01;
  localparam logic [1:0] PH_RD   = 2'b10;
  localparam logic [1:0] PH_WR   = 2'b11;

  wire cur_par = ^{ad_in, cbe_in};
  wire is_addr = (phase == PH_ADDR);
  wire is_rd   = (phase == PH_RD);
  wire is_wr   = (phase == PH_WR);

  wire gen_now      = (is_addr & is_master) | (is_rd & ~is_master) | (is_wr & is_master);
  wire gen_data_now = gen_now & ~is_addr;
  wire chk_addr_now = is_addr & ~is_master;
  wire chk_data_now = (is_rd & is_master) | (is_wr & ~is_master);

  logic exp_q, chk_addr_q, chk_data_q, chk_mst_q;
  logic gen_data_q1, gen_data_q2, gen_mst_q1, gen_mst_q2;
  logic perr_q, serr_q, merr_q;

  wire mism     = (chk_addr_q | chk_data_q) & (par_in != exp_q);
  wire perr_hit = mism & chk_data_q;
  wire serr_hit = mism & chk_addr_q;
  wire rpt_hit  = gen_data_q2 & ~perr_in_n;
  wire merr_hit = (perr_hit & chk_mst_q) | (rpt_hit & gen_mst_q2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out     <= 1'b0;
      par_oe      <= 1'b0;
      exp_q       <= 1'b0;
      chk_addr_q  <= 1'b0;
      chk_data_q  <= 1'b0;
      chk_mst_q   <= 1'b0;
      gen_data_q1 <= 1'b0;
      gen_data_q2 <= 1'b0;
      gen_mst_q1  <= 1'b0;
      gen_mst_q2  <= 1'b0;
    end else begin
      par_out     <= cur_par;
      par_oe      <= gen_now;
      exp_q       <= cur_par;
      chk_addr_q  <= chk_addr_now;
      chk_data_q  <= chk_data_now;
      chk_mst_q   <= is_master;
      gen_data_q1 <= gen_data_now;
      gen_data_q2 <= gen_data_q1;
      gen_mst_q1  <= is_master;
      gen_mst_q2  <= gen_mst_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q   <= 1'b0;
      serr_q   <= 1'b0;
      stat_det <= 1'b0;
      stat_rpt <= 1'b0;
      stat_sys <= 1'b0;
      merr_q   <= 1'b0;
      halt_req <= 1'b0;
    end else begin
      perr_q   <= perr_hit;
      serr_q   <= serr_hit;
      stat_det <= mism     | (stat_det & ~host_clr);
      stat_sys <= serr_hit | (stat_sys & ~host_clr);
      stat_rpt <= rpt_hit  | (stat_rpt & ~host_clr);
      merr_q   <= merr_hit | (merr_q & ~host_clr);
      halt_req <= (halt_req & ~host_clr) | (burst_end & merr_q);
    end
  end

  assign perr_n = ~perr_q;
  assign serr_n = ~serr_q;

  AST_OE_AFTER_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> (($past(phase) == PH_ADDR && $past(is_master)) ||
                ($past(phase) == PH_WR && $past(is_master)) ||
                ($past(phase) == PH_RD && !$past(is_master)))); // R2

  AST_PERR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> (($past(phase, 2) == PH_RD && $past(is_master, 2)) ||
                 ($past(phase, 2) == PH_WR && !$past(is_master, 2)))); // R4

  AST_SERR_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> ($past(phase, 2) == PH_ADDR && !$past(is_master, 2))); // R5

  AST_PIN_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_n || !serr_n) |-> stat_det); // R6

  AST_SYS_WITH_SERR: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> stat_sys); // R7

  AST_HALT_AT_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(burst_end)); // R9

  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stat_det) || $fell(stat_rpt) || $fell(halt_req)) |-> $past(host_clr)); // R10

endmodule

// File: tb/sim_pci_parity_unit.sv
module sim_pci_parity_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_in = '0;
  logic [1:0]  phase = 2'b00;
  logic        is_master = 1'b0;
  logic        par_in = 1'b0;
  logic        perr_in_n = 1'b1;
  logic        burst_end = 1'b0;
  logic        host_clr = 1'b0;
  logic par_out, par_oe, perr_n, serr_n, stat_det, stat_rpt, stat_sys, halt_req;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  pci_parity_unit u0 (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in), .phase(phase),
    .is_master(is_master), .par_in(par_in), .perr_in_n(perr_in_n),
    .burst_end(burst_end), .host_clr(host_clr), .par_out(par_out), .par_oe(par_oe),
    .perr_n(perr_n), .serr_n(serr_n), .stat_det(stat_det), .stat_rpt(stat_rpt),
    .stat_sys(stat_sys), .halt_req(halt_req));

  always #5 clk = ~clk;

  // history of what was applied, indexed by cycle modulo 8
  bit h_par[8], h_gen[8], h_gd[8], h_ca[8], h_cd[8], h_m[8], h_pin[8], h_pe[8], h_be[8], h_clr[8];
  bit m_det, m_rpt, m_sys, m_merr, m_halt;

  function automatic bit drives(input logic [1:0] ph, input bit m);
    case (ph)
      2'b01: return m;
      2'b10: return !m;
      2'b11: return m;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input string name, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic apply(input int k);
    int i;
    bit mst;
    logic [1:0] ph;
    i = k & 7;
    ph  = 2'($urandom_range(0, 3));
    mst = 1'($urandom_range(0, 1));
    // parity on the line covers the previous clock's bits, flipped now and then
    par_in    = h_par[(k - 1) & 7] ^ ($urandom_range(0, 7) == 0);
    ad_in     = $urandom;
    cbe_in    = 4'($urandom);
    phase     = ph;
    is_master = mst;
    perr_in_n = !($urandom_range(0, 9) == 0);
    burst_end = ($urandom_range(0, 5) == 0);
    host_clr  = ($urandom_range(0, 39) == 0);
    h_par[i] = ^{ad_in, cbe_in};
    h_gen[i] = drives(ph, mst);
    h_gd[i]  = drives(ph, mst) && ph != 2'b01;
    h_ca[i]  = (ph == 2'b01) && !mst;
    h_cd[i]  = (ph == 2'b10 && mst) || (ph == 2'b11 && !mst);
    h_m[i]   = mst;
    h_pin[i] = par_in;
    h_pe[i]  = perr_in_n;
    h_be[i]  = burst_end;
    h_clr[i] = host_clr;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      h_par[i] = 0; h_gen[i] = 0; h_gd[i] = 0; h_ca[i] = 0; h_cd[i] = 0;
      h_m[i] = 0; h_pin[i] = 0; h_pe[i] = 1; h_be[i] = 0; h_clr[i] = 0;
    end
    m_det = 0; m_rpt = 0; m_sys = 0; m_merr = 0; m_halt = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "par_oe", par_oe, 1'b0);
    check("R11", "par_out", par_out, 1'b0);
    check("R11", "perr_n", perr_n, 1'b1);
    check("R11", "serr_n", serr_n, 1'b1);
    check("R11", "stat_det", stat_det, 1'b0);
    check("R11", "stat_rpt", stat_rpt, 1'b0);
    check("R11", "stat_sys", stat_sys, 1'b0);
    check("R11", "halt_req", halt_req, 1'b0);
    rst_n = 1'b1;
    apply(0);
    for (int k = 1; k < 4000; k++) begin
      int p1, p2, p3;
      bit mism, e_perr, e_serr, e_rpt, e_merr, clr;
      @(negedge clk);
      p1 = (k - 1) & 7; p2 = (k - 2) & 7; p3 = (k - 3) & 7;
      mism   = (h_ca[p2] || h_cd[p2]) && (h_pin[p1] != h_par[p2]);
      e_perr = mism && h_cd[p2];
      e_serr = mism && h_ca[p2];
      e_rpt  = h_gd[p3] && !h_pe[p1];
      e_merr = (e_perr && h_m[p2]) || (e_rpt && h_m[p3]);
      clr    = h_clr[p1];
      m_halt = (m_halt && !clr) || (h_be[p1] && m_merr);
      m_merr = e_merr || (m_merr && !clr);
      m_det  = mism   || (m_det && !clr);
      m_sys  = e_serr || (m_sys && !clr);
      m_rpt  = e_rpt  || (m_rpt && !clr);
      check("R1", "par_out", par_out, h_par[p1]);
      check("R2", "par_oe", par_oe, h_gen[p1]);
      check("R3/R4", "perr_n", perr_n, !e_perr);
      check("R3/R5", "serr_n", serr_n, !e_serr);
      check("R6", "stat_det", stat_det, m_det);
      check("R7", "stat_sys", stat_sys, m_sys);
      check("R8", "stat_rpt", stat_rpt, m_rpt);
      check("R9/R10", "halt_req", halt_req, m_halt);
      apply(k);
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule